// File: doc/BRIEF.md
# Adjacent-Burst-Correcting Protected Register

This block is a K-bit register whose contents survive clustered upsets. Beside the K data flip-flops it keeps K check flip-flops. Check bit i is the XOR of data bit i and the data bit S places below it, wrapping around modulo K. A write stores the incoming word and its freshly computed check word in the same clock edge.

The read side is purely combinational and has no extra pipeline stage. Every cycle it recomputes K syndrome bits from the stored state. It repairs each data bit with a single AND of two syndrome bits that lie S apart. The stored vector holds the data in its low half and the checks in its high half. Any run of up to S neighbouring flips in that vector is undone, provided K is at least three times S.

A test-only injection port XORs a mask into the stored vector. An error flag reports any nonzero syndrome.

Top module: `adj_burst_reg`

## Requirements
- R1: While reset is active, and after it is released, with no write yet, `rd_data` is all zeros and `err_seen` is low. Reset clears data and checks, which is a valid codeword.
- R2: When `wr_en` is high at a rising edge, `rd_data` equals that `wr_data` from just after the edge.
- R3: Check bit i is stored as data[i] XOR data[(i−S) mod K]. Right after any write, `err_seen` is therefore low whatever the data.
- R4: Flipping any single data bit (physical index 0..K−1) leaves `rd_data` equal to the last written word.
- R5: Flipping any single check bit (physical index K..2K−1) leaves `rd_data` unchanged and raises `err_seen`.
- R6: Any run of 1..S adjacent flipped bits, at any start position in the 2K-bit physical vector, leaves `rd_data` equal to the last written word.
- R7: `err_seen` is high exactly while the stored vector is not a codeword. This includes every injected burst covered by R4 to R6.
- R8: When `wr_en` and `inj_en` are high in the same cycle, the write wins. The new word is stored clean and `err_seen` is low afterwards.
- R9: An injection XORs `inj_mask` into the current stored vector. Applying the same mask twice restores a clean codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Store `wr_data` with fresh check bits |
| wr_data | input | K | Word to store |
| inj_en | input | 1 | Apply fault mask to stored vector (test only) |
| inj_mask | input | 2K | Physical bit flips; bits 0..K−1 data, K..2K−1 checks |
| rd_data | output | K | Corrected data |
| err_seen | output | 1 | Some syndrome bit is nonzero |

## Verification
The bench sweeps every burst length from one to S over every start position of the 2K-bit vector. This covers bursts that straddle the boundary between the data and check halves, which a design with a wrong stride or wrong wrap direction would miscorrect. Single check-bit flips are checked so that a decoder that ORs syndrome bits instead of ANDing them is caught, since it would corrupt clean data. Write-versus-inject collisions and double injection of the same mask are checked as well. A store that let the injection win or overwrote the vector instead of XORing it would leave a dirty or wrong word.

// File: rtl/aecc_pkg.sv
package aecc_pkg;
  // Largest burst guaranteed correctable for a given width and stride.
  function automatic int burst_reach(int k, int s);
    int tail;
    tail = k - 2 * s;
    return (tail < s) ? tail : s;
  endfunction
endpackage

// File: rtl/aecc_encoder.sv
module aecc_encoder #(
  parameter int K = 16,
  parameter int S = 5
) (
  input  logic [K-1:0] data_i,
  output logic [K-1:0] chk_o
);
  for (genvar i = 0; i < K; i++) begin : g_chk
    localparam int LO = (i - S + K) % K;
    assign chk_o[i] = data_i[i] ^ data_i[LO];
  end
endmodule

// File: rtl/aecc_syndrome.sv
module aecc_syndrome #(
  parameter int K = 16,
  parameter int S = 5
) (
  input  logic [K-1:0] data_i,
  input  logic [K-1:0] chk_i,
  output logic [K-1:0] syn_o
);
  for (genvar i = 0; i < K; i++) begin : g_syn
    localparam int LO = (i - S + K) % K;
    assign syn_o[i] = chk_i[i] ^ data_i[i] ^ data_i[LO];
  end
endmodule

// File: rtl/aecc_corrector.sv
module aecc_corrector #(
  parameter int K = 16,
  parameter int S = 5
) (
  input  logic [K-1:0] data_i,
  input  logic [K-1:0] syn_i,
  output logic [K-1:0] data_o
);
  for (genvar i = 0; i < K; i++) begin : g_fix
    localparam int HI = (i + S) % K;
    assign data_o[i] = data_i[i] ^ (syn_i[i] & syn_i[HI]);
  end
endmodule

// File: rtl/aecc_store.sv
module aecc_store #(
  parameter int K = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [K-1:0]   wr_data,
  input  logic [K-1:0]   wr_chk,
  input  logic           inj_en,
  input  logic [2*K-1:0] inj_mask,
  output logic [2*K-1:0] vec_o
);
  localparam int W = 2 * K;

  logic [W-1:0] vec_q;
  logic [W-1:0] vec_d;
  logic         load;

  always_comb begin
    vec_d = vec_q;
    load  = wr_en | inj_en;
    if (wr_en) begin
      vec_d = {wr_chk, wr_data};
    end else if (inj_en) begin
      vec_d = vec_q ^ inj_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (load) begin
      vec_q <= vec_d;
    end
  end

  assign vec_o = vec_q;

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vec_q[K-1:0] == $past(wr_data));

  assert_inject_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && !wr_en) |=> vec_q == ($past(vec_q) ^ $past(inj_mask)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_en && !wr_en) |=> $stable(vec_q));
endmodule

// File: rtl/adj_burst_reg.sv
module adj_burst_reg #(
  parameter int K = 16,
  parameter int S = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [K-1:0]   wr_data,
  input  logic           inj_en,
  input  logic [2*K-1:0] inj_mask,
  output logic [K-1:0]   rd_data,
  output logic           err_seen
);
  localparam int W     = 2 * K;
  localparam int BURST = aecc_pkg::burst_reach(K, S);

  initial begin
    assert_param_legal: assert (S >= 1 && K >= 3 * S && BURST == S);
  end

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [K-1:0] enc_chk;
  logic [W-1:0] vec;
  logic [K-1:0] syn;

  aecc_encoder #(.K(K), .S(S)) u_enc (
    .data_i (wr_data),
    .chk_o  (enc_chk)
  );

  aecc_store #(.K(K)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_chk   (enc_chk),
    .inj_en   (inj_en),
    .inj_mask (inj_mask),
    .vec_o    (vec)
  );

  aecc_syndrome #(.K(K), .S(S)) u_syn (
    .data_i (vec[K-1:0]),
    .chk_i  (vec[W-1:K]),
    .syn_o  (syn)
  );

  aecc_corrector #(.K(K), .S(S)) u_fix (
    .data_i (vec[K-1:0]),
    .syn_i  (syn),
    .data_o (rd_data)
  );

  assign err_seen = |syn;

  assert_clean_after_write_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> !err_seen);

  assert_write_priority_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && inj_en) |=> (rd_data == $past(wr_data)) && !err_seen);

  assert_single_flip_repaired_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en && inj_en && !err_seen && $countones(inj_mask) == 1) |=> $stable(rd_data) && err_seen);
endmodule

// File: tb/adj_burst_reg_tb.sv
module adj_burst_reg_tb;
  localparam int K = 16;
  localparam int S = 5;
  localparam int W = 2 * K;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [K-1:0] wr_data = '0;
  logic         inj_en = 1'b0;
  logic [W-1:0] inj_mask = '0;
  logic [K-1:0] rd_data;
  logic         err_seen;

  always #2.5 clk = ~clk;

  adj_burst_reg #(.K(K), .S(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .inj_en(inj_en), .inj_mask(inj_mask), .rd_data(rd_data), .err_seen(err_seen)
  );

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [K-1:0] exp_data_q[$];
  logic         exp_err_q[$];
  string        tag_q[$];

  // Driver: one operation per cycle, expectation queued after the edge.
  task automatic apply(input logic we, input logic [K-1:0] d, input logic ie,
                       input logic [W-1:0] m, input logic [K-1:0] ed,
                       input logic ee, input string tag);
    @(negedge clk);
    wr_en = we; wr_data = d; inj_en = ie; inj_mask = m;
    @(posedge clk);
    #1;
    wr_en = 1'b0; inj_en = 1'b0; inj_mask = '0;
    exp_data_q.push_back(ed);
    exp_err_q.push_back(ee);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares at the falling edge, away from the update edge.
  always @(negedge clk) begin
    if (exp_data_q.size() > 0) begin
      logic [K-1:0] ed;
      logic         ee;
      string        tg;
      ed = exp_data_q.pop_front();
      ee = exp_err_q.pop_front();
      tg = tag_q.pop_front();
      applied++;
      if (rd_data !== ed) begin
        miscompares++;
        $display("FAIL %s rd_data actual=%h expected=%h", tg, rd_data, ed);
      end
      if (err_seen !== ee) begin
        miscompares++;
        $display("FAIL %s err_seen actual=%b expected=%b", tg, err_seen, ee);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    logic [K-1:0] d;
    logic [W-1:0] m;
    string tg;
    // R1: during reset
    repeat (3) @(negedge clk);
    applied++;
    if (rd_data !== '0 || err_seen !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 in reset actual=%h/%b expected=0/0", rd_data, err_seen);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: after release, no write
    apply(1'b0, '0, 1'b0, '0, '0, 1'b0, "R1");

    // R2, R3: writes of several patterns leave a clean codeword
    apply(1'b1, 16'hFFFF, 1'b0, '0, 16'hFFFF, 1'b0, "R2");
    apply(1'b1, 16'h0001, 1'b0, '0, 16'h0001, 1'b0, "R3");
    apply(1'b1, 16'hA5C3, 1'b0, '0, 16'hA5C3, 1'b0, "R2");

    // R4, R5, R6, R7: every burst length 1..S at every start position
    for (int len = 1; len <= S; len++) begin
      for (int st = 0; st + len <= W; st++) begin
        d = 16'h3C96 ^ K'(st * 16'h9E37) ^ K'(len * 16'h1F0B);
        m = '0;
        for (int j = 0; j < len; j++) m[st + j] = 1'b1;
        if (len == 1 && st < K) tg = "R4";
        else if (len == 1) tg = "R5";
        else tg = "R6";
        apply(1'b1, d, 1'b0, '0, d, 1'b0, "R3");
        apply(1'b0, '0, 1'b1, m, d, 1'b1, tg); // R7: flag must be raised
      end
    end

    // R8: write and injection collide, write wins
    apply(1'b1, 16'h1234, 1'b0, '0, 16'h1234, 1'b0, "R2");
    apply(1'b1, 16'hBEEF, 1'b1, 32'h0000_0018, 16'hBEEF, 1'b0, "R8");

    // R9: same mask twice restores a clean codeword
    apply(1'b0, '0, 1'b1, 32'h0001_8000, 16'hBEEF, 1'b1, "R9");
    apply(1'b0, '0, 1'b1, 32'h0001_8000, 16'hBEEF, 1'b0, "R9");
    // R9/R7: idle cycle keeps state and flag
    apply(1'b0, '0, 1'b0, '0, 16'hBEEF, 1'b0, "R9");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule